// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by walking a multi-level radix tree held in memory. A translation request carries the effective address and a process ID. The walker first checks the process-table descriptor (a plain configuration input), then reads the process-table entry for that ID. That entry gives the root directory base, the root index width and the total translated size. The walker then reads one directory entry per level until it finds a leaf. The result is the real address, the page size in bits and the leaf entry itself.

All memory traffic goes through one 64-bit read port with valid/ready on both the request and the response, and only one read is in flight at a time. The memory may hold off a request by keeping `mem_req_ready` low. The request address is then held stable until it is accepted. The walker raises `mem_resp_ready` only while it waits for its single outstanding read.

A translation request is accepted only while the walker is idle (`req_ready` high). The outcome is presented for exactly one cycle on the `done` outputs. That outcome is either a translation or a fault with a cause code. Nested second-stage translation and permission checks are not part of the block.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: The table base is descriptor bits 59:12, with bits 11:0 taken as zero. The table size is 2^(descriptor[4:0]+12) bytes. If the base has any bit set below that size, the walker reports fault cause 1 (bad configuration) and issues no memory read.
- R3: Each process-table entry takes 16 bytes, so the entry lies at offset PID×16. If that offset is greater than or equal to the table size, the walker reports fault cause 2 (no entry) and issues no memory read.
- R4: The first read goes to base + PID×16. In the returned entry, the total size is {bits 62:61, bits 7:5} + 31. The root base is bits 59:8 with bits 7:0 zero, and the root index width is bits 4:0.
- R5: Only these tree shapes are allowed. At level 0 the total size must be 52 and the index width 13. At levels 1 and 2 the index width must be 9. At level 3 the index width must be 9 or 5. A fourth level is never allowed. Any other combination gives fault cause 1 before that level is read.
- R6: The entry address at each level is computed as follows.
  - The index is the effective address shifted right by (remaining size − index width) and masked to the index width.
  - The base has its low (index width + 3) bits cleared.
  - The entry address is the cleared base + 8×index.
  - A misaligned base is corrected in this way and never faults.
- R7: A directory entry with bit 63 clear gives fault cause 3 (no PTE). A translation that completes reports cause 0, and `done_fault` is 1 exactly when the cause is nonzero.
- R8: A directory entry with bits 63 and 62 both set is a leaf.
  - After each level, the remaining size is reduced by that level's index width.
  - At the leaf, the page size is the remaining size.
  - The real address is leaf bits 56:12 above the page size, joined with the effective address bits below it.
  - The leaf entry is returned unchanged.
- R9: Handshake rules:
  - A memory request stays asserted with a stable address until it is accepted.
  - No new request is issued while a response is awaited.
  - `req_ready` is high only when the walker is idle.
  - `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ea | input | 64 | Effective address to translate |
| req_pid | input | PID_W | Process ID indexing the process table |
| tbl_desc | input | 64 | Process-table descriptor (base and size) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 64-bit read |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_ready | output | 1 | Walker waiting for read data |
| mem_resp_data | input | 64 | Read data |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Result is a fault |
| done_cause | output | 2 | 0 none, 1 bad configuration, 2 no entry, 3 no PTE |
| done_raddr | output | 64 | Translated real address |
| done_psize | output | 6 | Page size in bits |
| done_pte | output | 64 | Leaf entry |

## Verification
Some faults can only be reached through a carefully built memory image. The fourth-level shape fault needs a non-leaf entry at level 3. A bad index width deep in the tree needs the parent entry to carry it. Silently corrected base misalignment only shows up if the walk still lands on the right entries. The bench therefore builds a fresh sparse memory image for every walk from the same index arithmetic stated in the requirements. It then compares the outcome and the number of reads taken against its own expectation. The memory model stalls requests and delays responses in a rotating pattern, so the hold and single-outstanding rules are exercised across every level.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 64;
  localparam int PSZ_W  = 6;
  localparam int NLS_W  = 5;
  localparam int LVL_W  = 3;

  localparam int ROOT_PSZ  = 52;
  localparam int ROOT_NLS  = 13;
  localparam int MID_NLS   = 9;
  localparam int SMALL_NLS = 5;
  localparam int RTS_BIAS  = 31;
  localparam int PT_SHIFT  = 12;
  localparam int PTE_SHIFT = 4;

  localparam logic [DATA_W-1:0] PTB_MASK = 64'h0FFF_FFFF_FFFF_F000;
  localparam logic [DATA_W-1:0] NLB_MASK = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [DATA_W-1:0] RPN_MASK = 64'h01FF_FFFF_FFFF_F000;

  localparam int BIT_VALID = 63;
  localparam int BIT_LEAF  = 62;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BAD_CFG = 2'd1,
    CAUSE_NO_ENT  = 2'd2,
    CAUSE_NO_PTE  = 2'd3
  } cause_e;
endpackage

// File: rtl/rw_ptab_check.sv
module rw_ptab_check
  import rw_pkg::*;
#(
  parameter int PID_W = 16
) (
  input  logic [DATA_W-1:0] desc,
  input  logic [PID_W-1:0]  pid,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              bad_base,
  output logic              beyond
);
  logic [ADDR_W-1:0] tbase, offs, size_m;
  logic [PSZ_W-1:0]  szlog;

  always_comb begin
    tbase      = desc & PTB_MASK;
    szlog      = PSZ_W'(desc[NLS_W-1:0]) + PSZ_W'(PT_SHIFT);
    size_m     = (ADDR_W'(1) << szlog) - ADDR_W'(1);
    offs       = ADDR_W'(pid) << PTE_SHIFT;
    bad_base   = |(tbase & size_m);
    beyond     = |(offs >> szlog);
    entry_addr = tbase + offs;
  end
endmodule

// File: rtl/rw_shape_check.sv
module rw_shape_check
  import rw_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic [PSZ_W-1:0] psize,
  input  logic [NLS_W-1:0] nls,
  output logic             ok
);
  always_comb begin
    case (level)
      LVL_W'(0): ok = (psize == PSZ_W'(ROOT_PSZ)) && (nls == NLS_W'(ROOT_NLS));
      LVL_W'(1),
      LVL_W'(2): ok = (nls == NLS_W'(MID_NLS));
      LVL_W'(3): ok = (nls == NLS_W'(MID_NLS)) || (nls == NLS_W'(SMALL_NLS));
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/rw_entry_addr.sv
module rw_entry_addr
  import rw_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] ea,
  input  logic [PSZ_W-1:0]  rem,
  input  logic [NLS_W-1:0]  nls,
  output logic [ADDR_W-1:0] addr
);
  logic [PSZ_W-1:0]  shamt, algn;
  logic [ADDR_W-1:0] idx_m, base_m, idx;

  always_comb begin
    shamt  = rem - PSZ_W'(nls);
    algn   = PSZ_W'(nls) + PSZ_W'(3);
    idx_m  = (ADDR_W'(1) << nls) - ADDR_W'(1);
    base_m = (ADDR_W'(1) << algn) - ADDR_W'(1);
    idx    = (ea >> shamt) & idx_m;
    addr   = (base & ~base_m) + (idx << 3);
  end
endmodule

// File: rtl/rw_leaf_form.sv
module rw_leaf_form
  import rw_pkg::*;
(
  input  logic [DATA_W-1:0] pte,
  input  logic [ADDR_W-1:0] ea,
  input  logic [PSZ_W-1:0]  psize,
  output logic [ADDR_W-1:0] raddr
);
  logic [ADDR_W-1:0] pg_m;

  always_comb begin
    pg_m  = (ADDR_W'(1) << psize) - ADDR_W'(1);
    raddr = ((pte & RPN_MASK) & ~pg_m) | (ea & pg_m);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int PID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_ea,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [63:0]       tbl_desc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_resp_valid,
  output logic              mem_resp_ready,
  input  logic [63:0]       mem_resp_data,
  output logic              done,
  output logic              done_fault,
  output logic [1:0]        done_cause,
  output logic [63:0]       done_raddr,
  output logic [5:0]        done_psize,
  output logic [63:0]       done_pte
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_PRTE, S_WAIT_PRTE, S_FETCH_PDE, S_WAIT_PDE, S_DONE, S_FAULT
  } st_e;

  st_e               st;
  logic [ADDR_W-1:0] ea_q, addr_q, raddr_q;
  logic [PSZ_W-1:0]  rem_q, psize_q;
  logic [NLS_W-1:0]  nls_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] pte_q;
  cause_e            cause_q;

  // process-table checks on the request
  logic [ADDR_W-1:0] prte_addr;
  logic              pt_bad, pt_beyond;

  rw_ptab_check #(.PID_W(PID_W)) u_ptab (
    .desc(tbl_desc), .pid(req_pid), .entry_addr(prte_addr),
    .bad_base(pt_bad), .beyond(pt_beyond)
  );

  // next-level parameters from the returned entry
  logic [PSZ_W-1:0]  rts, nx_rem;
  logic [NLS_W-1:0]  nx_nls;
  logic [LVL_W-1:0]  nx_lvl;
  logic [ADDR_W-1:0] nx_base, nx_addr, leaf_raddr;
  logic              shape_ok, is_prte;

  always_comb begin
    is_prte = (st == S_WAIT_PRTE);
    rts     = PSZ_W'({mem_resp_data[62:61], mem_resp_data[7:5]}) + PSZ_W'(RTS_BIAS);
    nx_base = mem_resp_data & NLB_MASK;
    nx_nls  = mem_resp_data[NLS_W-1:0];
    nx_rem  = is_prte ? rts : (rem_q - PSZ_W'(nls_q));
    nx_lvl  = is_prte ? '0 : (lvl_q + LVL_W'(1));
  end

  rw_shape_check u_shape (
    .level(nx_lvl), .psize(nx_rem), .nls(nx_nls), .ok(shape_ok)
  );

  rw_entry_addr u_eaddr (
    .base(nx_base), .ea(ea_q), .rem(nx_rem), .nls(nx_nls), .addr(nx_addr)
  );

  rw_leaf_form u_leaf (
    .pte(mem_resp_data), .ea(ea_q), .psize(nx_rem), .raddr(leaf_raddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ea_q    <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      nls_q   <= '0;
      lvl_q   <= '0;
      raddr_q <= '0;
      psize_q <= '0;
      pte_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          cause_q <= CAUSE_NONE;
          if (pt_bad) begin
            cause_q <= CAUSE_BAD_CFG;
            st      <= S_FAULT;
          end else if (pt_beyond) begin
            cause_q <= CAUSE_NO_ENT;
            st      <= S_FAULT;
          end else begin
            addr_q <= prte_addr;
            st     <= S_FETCH_PRTE;
          end
        end
        S_FETCH_PRTE: if (mem_req_ready) st <= S_WAIT_PRTE;
        S_FETCH_PDE:  if (mem_req_ready) st <= S_WAIT_PDE;
        S_WAIT_PRTE, S_WAIT_PDE: if (mem_resp_valid) begin
          if (!is_prte && !mem_resp_data[BIT_VALID]) begin
            cause_q <= CAUSE_NO_PTE;
            st      <= S_FAULT;
          end else if (!is_prte && mem_resp_data[BIT_LEAF]) begin
            raddr_q <= leaf_raddr;
            psize_q <= nx_rem;
            pte_q   <= mem_resp_data;
            cause_q <= CAUSE_NONE;
            st      <= S_DONE;
          end else begin
            rem_q <= nx_rem;
            nls_q <= nx_nls;
            lvl_q <= nx_lvl;
            if (!shape_ok) begin
              cause_q <= CAUSE_BAD_CFG;
              st      <= S_FAULT;
            end else begin
              addr_q <= nx_addr;
              st     <= S_FETCH_PDE;
            end
          end
        end
        S_DONE, S_FAULT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready      = (st == S_IDLE);
    mem_req_valid  = (st == S_FETCH_PRTE) || (st == S_FETCH_PDE);
    mem_req_addr   = addr_q;
    mem_resp_ready = (st == S_WAIT_PRTE) || (st == S_WAIT_PDE);
    done           = (st == S_DONE) || (st == S_FAULT);
    done_fault     = (st == S_FAULT);
    done_cause     = cause_q;
    done_raddr     = raddr_q;
    done_psize     = psize_q;
    done_pte       = pte_q;
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_resp_ready,
  input logic        done,
  input logic        done_fault,
  input logic [1:0]  done_cause,
  input logic [5:0]  done_psize,
  input logic [63:0] done_pte
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_resp_ready |-> !mem_req_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !mem_resp_ready && !done);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_fault == (done_cause != 2'd0)));

  p_leaf_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> (done_psize == 6'd12 || done_psize == 6'd16 ||
      done_psize == 6'd21 || done_psize == 6'd30 || done_psize == 6'd39));

  p_leaf_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> done_pte[63] && done_pte[62]);
endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_resp_ready(mem_resp_ready),
  .done(done), .done_fault(done_fault), .done_cause(done_cause),
  .done_psize(done_psize), .done_pte(done_pte)
);

// File: tb/radix_walker_test.sv
`timescale 1ns/1ps
module radix_walker_test;
  localparam int PID_W = 16;
  localparam logic [63:0] NLB = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] RPNM = 64'h01FF_FFFF_FFFF_F000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [63:0] req_ea = '0, tbl_desc = '0;
  logic [PID_W-1:0] req_pid = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_resp_ready;
  logic mem_resp_valid = 1'b0;
  logic [63:0] mem_req_addr, mem_resp_data = '0;
  logic req_ready, done, done_fault;
  logic [1:0] done_cause;
  logic [63:0] done_raddr, done_pte;
  logic [5:0] done_psize;

  always #10 clk = ~clk;

  radix_walker #(.PID_W(PID_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_pid(req_pid), .tbl_desc(tbl_desc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_ready(mem_resp_ready), .mem_resp_data(mem_resp_data),
    .done(done), .done_fault(done_fault), .done_cause(done_cause),
    .done_raddr(done_raddr), .done_psize(done_psize), .done_pte(done_pte)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sparse memory with stalls and variable latency
  logic [63:0] mem [logic [63:0]];
  int reads = 0, tick = 0, lat = 0;
  bit pend = 0, rq_fire = 0, rs_fire = 0;
  logic [63:0] cap = '0, paddr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0; mem_resp_valid = 1'b0; pend = 0; rq_fire = 0; rs_fire = 0;
    end else begin
      if (rs_fire) begin mem_resp_valid = 1'b0; pend = 0; end
      if (rq_fire) begin pend = 1; lat = reads % 3; paddr = cap; reads++; end
      if (pend && !mem_resp_valid) begin
        if (lat == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data = mem.exists(paddr) ? mem[paddr] : 64'd0;
        end else lat--;
      end
      tick++;
      mem_req_ready = (tick % 4 != 2);
      rq_fire = mem_req_valid && mem_req_ready;
      cap = mem_req_addr;
      rs_fire = mem_resp_valid && mem_resp_ready;
    end
  end

  // build a tree image, run one walk, check the outcome
  task automatic walk(input logic [63:0] ea, input int pid, input int szf,
                      input logic [63:0] ptb, input int lf, input int nls3,
                      input int inv_lvl, input int bad_lvl, input bit mis,
                      input bit extra, input int rts, input int exp_pre,
                      input string tag);
    int nlsv[4];
    logic [63:0] bases[4];
    logic [63:0] misoff, addr, prte, nb, m, exp_raddr, exp_pte, rpnf;
    int rem, exp_cause, exp_reads, exp_psize, cur, nxt, r0, wd;
    nlsv = '{13, 9, 9, nls3};
    bases = '{64'h20_0000, 64'h30_0000, 64'h40_0000, 64'h50_0000};
    misoff = mis ? 64'h100 : 64'h0;
    rpnf = (ea * 64'h5DEE_CE66_D123) & RPNM;
    exp_raddr = '0; exp_pte = '0; exp_psize = 0;
    mem.delete();
    r0 = rts - 31;
    prte = (64'((r0 >> 3) & 3) << 61) | (64'(r0 & 7) << 5) |
           ((bases[0] | misoff) & NLB) | 64'((bad_lvl == 0) ? 7 : 13);
    mem[ptb + 64'(pid) * 16] = prte;
    exp_cause = 0;
    if (exp_pre >= 0) begin
      exp_cause = exp_pre; exp_reads = 0;
    end else begin
      exp_reads = 1; rem = rts;
      if (rts != 52) exp_cause = 1;
      else begin
        for (int l = 0; l <= 4; l++) begin
          cur = (l == bad_lvl) ? 7 : ((l < 4) ? nlsv[l] : 9);
          if (l == 4 || l == bad_lvl) begin exp_cause = 1; break; end
          addr = bases[l] + 8 * ((ea >> (rem - cur)) & ((64'd1 << cur) - 1));
          exp_reads++; rem = rem - cur;
          if (l == inv_lvl) begin
            mem[addr] = 64'h0000_0000_0030_0000; exp_cause = 3; break;
          end
          if (l == lf && !extra) begin
            exp_pte = 64'hC000_0000_0000_0000 | rpnf;
            mem[addr] = exp_pte;
            m = (64'd1 << rem) - 1;
            exp_psize = rem;
            exp_raddr = (rpnf & ~m) | (ea & m);
            break;
          end
          nxt = (l + 1 == bad_lvl) ? 7 : ((l + 1 < 4) ? nlsv[l+1] : 9);
          nb = (l + 1 < 4) ? bases[l+1] : 64'h60_0000;
          mem[addr] = 64'h8000_0000_0000_0000 | ((nb | misoff) & NLB) | 64'(nxt);
        end
      end
    end
    @(negedge clk);
    tbl_desc = (ptb & 64'h0FFF_FFFF_FFFF_F000) | 64'(szf);
    req_ea = ea; req_pid = PID_W'(pid); req_valid = 1'b1;
    r0 = reads;
    chk({tag, " R9 req_ready idle"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wd = 0;
    while (!done && wd < 400) begin @(negedge clk); wd++; end
    if (!done) begin
      failures++; checks++;
      $display("FAIL %s R9 no done actual=0 expected=1", tag);
    end else begin
      chk({tag, " R7 cause"}, 64'(done_cause), 64'(exp_cause));
      chk({tag, " R7 fault flag"}, 64'(done_fault), 64'(exp_cause != 0));
      chk({tag, " R4 read count"}, 64'(reads - r0), 64'(exp_reads));
      if (exp_cause == 0) begin
        chk({tag, " R8 psize"}, 64'(done_psize), 64'(exp_psize));
        chk({tag, " R8 raddr"}, done_raddr, exp_raddr);
        chk({tag, " R8 pte"}, done_pte, exp_pte);
      end
      @(negedge clk);
      chk({tag, " R9 done pulse"}, 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] ea;
    int pids[3];
    pids = '{0, 7, 4095};
    repeat (3) @(negedge clk);
    chk("R1 reset req_ready", 64'(req_ready), 64'd1);
    chk("R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release done", 64'(done), 64'd0);

    // R8 R6 R4: shape sweep, leaf at every level, both last-level widths
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 3; p++) begin
          ea = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1 + 5 * s)) ^ (64'(k) << 17);
          walk(ea, pids[p], 4, 64'h10_0000, (s < 4) ? s : 3, (s == 4) ? 5 : 9,
               -1, -1, 0, 0, 52, -1, "R8 sweep");
        end
      end
    end
    // R6: misaligned directory bases cleared
    for (int l = 1; l < 4; l++)
      walk(64'h0003_A5C3_1234_5678, 3, 4, 64'h10_0000, l, 9, -1, -1, 1, 0, 52, -1, "R6 misaligned base");
    // R7: invalid entry at each level
    for (int l = 0; l < 4; l++)
      walk(64'h000F_0F0F_0F0F_0F0F, 5, 4, 64'h10_0000, 3, 9, l, -1, 0, 0, 52, -1, "R7 invalid entry");
    // R5: bad width at each level, bad total size, level four
    for (int l = 0; l < 4; l++)
      walk(64'h0001_2345_6789_ABCD, 2, 4, 64'h10_0000, 3, 9, -1, l, 0, 0, 52, -1, "R5 bad width");
    walk(64'h0001_2345_6789_ABCD, 2, 4, 64'h10_0000, 3, 9, -1, -1, 0, 0, 48, -1, "R5 bad total");
    walk(64'h0001_2345_6789_ABCD, 2, 4, 64'h10_0000, 3, 9, -1, -1, 0, 0, 62, -1, "R5 max total");
    walk(64'h0001_2345_6789_ABCD, 2, 4, 64'h10_0000, 3, 9, -1, -1, 0, 1, 52, -1, "R5 level four");
    walk(64'h0001_2345_6789_ABCD, 2, 4, 64'h10_0000, 3, 5, -1, -1, 0, 1, 52, -1, "R5 level four small");
    // R3: table bounds
    walk(64'h0000_0000_0012_3456, 4096, 4, 64'h10_0000, 3, 9, -1, -1, 0, 0, 52, 2, "R3 pid beyond");
    walk(64'h0000_0000_0012_3456, 255, 0, 64'h10_0000, 3, 9, -1, -1, 0, 0, 52, -1, "R3 pid last small");
    walk(64'h0000_0000_0012_3456, 256, 0, 64'h10_0000, 3, 9, -1, -1, 0, 0, 52, 2, "R3 pid beyond small");
    // R2: misaligned table base
    walk(64'h0000_0000_0012_3456, 1, 4, 64'h10_8000, 3, 9, -1, -1, 0, 0, 52, 1, "R2 table misaligned");
    walk(64'h0000_0000_0012_3456, 1, 3, 64'h10_8000, 2, 9, -1, -1, 0, 0, 52, -1, "R2 table aligned");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule